// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Arbitration

This block copies a block of words between a peripheral and system memory without involving the processor. A host loads a start address, a word count, a direction and a tenure mode in one `start_i` cycle. The engine then asks the processor for the shared bus with a request line. It drives the memory address, data and write-enable lines only while the processor's grant is present.

Two tenure modes exist. In the held mode the engine keeps the bus from the first word to the last, and stalls in place when the peripheral is not ready. In the stealing mode the engine gives the bus back after every word. It then waits for the peripheral to signal readiness before it asks again. When the last word has moved, a sticky completion flag rises and the request stays low until the next start.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `bus_req_o`, `bus_en_o`, `busy_o` and `done_o` are all 0.
- R2: `bus_req_o` is raised only while `busy_o` is 1, and never while the engine waits for `dev_ready_i`. After a start, no request appears until `dev_ready_i` is 1.
- R3: `bus_en_o` (and with it any nonzero memory address, data or write strobe) is 1 only while both `bus_req_o` and `bus_grant_i` are 1.
- R4: With `cfg_mode_i`=0 (held mode), an N-word block uses exactly one grant tenure. With a grant that follows the request by one cycle and a ready peripheral, `done_o` rises N+4 cycles after the start edge, counting the start edge.
- R5: With `cfg_mode_i`=1 (stealing mode), each word uses its own tenure, and `bus_req_o` is 0 in the cycle after every word. An N-word block takes N tenures and finishes 4N+1 cycles after the start edge under the same grant model.
- R6: Word k of a block (k from 0) goes to or comes from address `cfg_addr_i`+k. No address outside that range is written.
- R7: With `cfg_dir_i`=0 (peripheral to memory), each word pulses `mem_we_o` with `mem_wdata_o` equal to `dev_data_i` and pulses `dev_ack_o`.
- R8: With `cfg_dir_i`=1 (memory to peripheral), each word pulses `dev_wr_o` with `dev_data_o` equal to `mem_rdata_i` at the driven address. `mem_we_o` stays 0.
- R9: `done_o` rises in the same cycle that the request falls after the last word. It stays 1 until the next accepted start, which clears it one cycle later.
- R10: A start with `cfg_count_i`=0 sets `done_o` one cycle later, with no request and no bus activity.
- R11: A start pulse while `busy_o` is 1 is ignored. The running block finishes at its original addresses and length.
- R12: In held mode, while `dev_ready_i` is 0 no word moves, and `bus_req_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load configuration and begin a block (ignored while busy) |
| cfg_addr_i | input | AW | Start address of the block |
| cfg_count_i | input | CW | Number of words |
| cfg_dir_i | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_mode_i | input | 1 | 0: held tenure, 1: one word per tenure |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | Sticky completion flag |
| bus_req_o | output | 1 | Request for the shared bus |
| bus_grant_i | input | 1 | Processor has released the bus |
| bus_en_o | output | 1 | Engine is driving the bus this cycle |
| mem_addr_o | output | AW | Memory address (0 when not driving) |
| mem_wdata_o | output | DW | Memory write data (0 when not driving) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | DW | Memory read data for the driven address |
| dev_ready_i | input | 1 | Peripheral can supply or accept a word |
| dev_data_i | input | DW | Word from the peripheral |
| dev_ack_o | output | 1 | Peripheral word consumed |
| dev_data_o | output | DW | Word to the peripheral |
| dev_wr_o | output | 1 | Peripheral write strobe |

## Verification
A start is taken at the first edge. The request follows one edge later. Under a one-cycle grant model, the first word moves in the fourth cycle. So `done_o` is due N+4 edges after the start edge in held mode and 4N+1 edges after it in stealing mode. The bench counts edges from the start edge up to the first falling edge at which `done_o` reads 1, and compares that count with these numbers. It samples every output at the falling edge, half a period after the register update it depends on. Stall and ignored-start checks are taken a fixed number of edges after the stimulus, before the next stimulus is applied.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_XFER = 2'd3
  } dma_state_e;

  typedef enum logic {
    MODE_BURST = 1'b0,
    MODE_STEAL = 1'b1
  } dma_mode_e;

  typedef enum logic {
    DIR_DEV2MEM = 1'b0,
    DIR_MEM2DEV = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  dma_dir_e      dir_i,
  input  dma_mode_e     mode_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] count_o,
  output dma_dir_e      dir_o,
  output dma_mode_e     mode_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  dma_dir_e      dir_q;
  dma_mode_e     mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= DIR_DEV2MEM;
      mode_q  <= MODE_BURST;
    end else if (load_i) begin
      addr_q  <= addr_i;
      count_q <= count_i;
      dir_q   <= dir_i;
      mode_q  <= mode_i;
    end else if (step_i) begin
      addr_q  <= addr_q + ADDR_ONE;
      count_q <= count_q - CNT_ONE;
    end
  end

  assign addr_o  = addr_q;
  assign count_o = count_q;
  assign dir_o   = dir_q;
  assign mode_o  = mode_q;
  assign last_o  = (count_q == CNT_ONE);
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      cnt_zero_i,
  input  dma_mode_e mode_i,
  input  logic      last_i,
  input  logic      dev_ready_i,
  input  logic      grant_i,
  output logic      load_o,
  output logic      fire_o,
  output logic      req_o,
  output logic      drive_o,
  output logic      busy_o,
  output logic      done_o
);
  dma_state_e state_q, state_d;
  logic       done_q, done_d;

  assign load_o  = start_i && (state_q == ST_IDLE);
  assign drive_o = (state_q == ST_XFER) && grant_i;
  assign fire_o  = drive_o && dev_ready_i;
  assign req_o   = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (cnt_zero_i) begin
          done_d = 1'b1;
        end else begin
          done_d  = 1'b0;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: if (dev_ready_i) state_d = ST_REQ;
      ST_REQ:  if (grant_i) state_d = ST_XFER;
      ST_XFER: if (fire_o) begin
        if (last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (mode_i == MODE_STEAL) begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          drive_i,
  input  logic          fire_i,
  input  dma_dir_e      dir_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] dev_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic [DW-1:0] dev_data_o,
  output logic          dev_wr_o,
  output logic          dev_ack_o
);
  logic to_mem;
  assign to_mem = (dir_i == DIR_DEV2MEM);

  // outputs parked at zero while the bus belongs to the processor
  assign mem_addr_o  = drive_i ? addr_i : '0;
  assign mem_wdata_o = (drive_i && to_mem) ? dev_data_i : '0;
  assign mem_we_o    = fire_i && to_mem;
  assign dev_ack_o   = fire_i && to_mem;
  assign dev_data_o  = (drive_i && !to_mem) ? mem_rdata_i : '0;
  assign dev_wr_o    = fire_i && !to_mem;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic          cfg_dir_i,
  input  logic          cfg_mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  output logic          bus_en_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          dev_ready_i,
  input  logic [DW-1:0] dev_data_i,
  output logic          dev_ack_o,
  output logic [DW-1:0] dev_data_o,
  output logic          dev_wr_o
);
  logic          load, fire, drive, last;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_count;
  dma_dir_e      cur_dir;
  dma_mode_e     cur_mode;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (cfg_addr_i),
    .count_i (cfg_count_i),
    .dir_i   (dma_dir_e'(cfg_dir_i)),
    .mode_i  (dma_mode_e'(cfg_mode_i)),
    .step_i  (fire),
    .addr_o  (cur_addr),
    .count_o (cur_count),
    .dir_o   (cur_dir),
    .mode_o  (cur_mode),
    .last_o  (last)
  );

  dma_arb_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cnt_zero_i  (cfg_count_i == '0),
    .mode_i      (cur_mode),
    .last_i      (last),
    .dev_ready_i (dev_ready_i),
    .grant_i     (bus_grant_i),
    .load_o      (load),
    .fire_o      (fire),
    .req_o       (bus_req_o),
    .drive_o     (drive),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  dma_bus_port #(.AW(AW), .DW(DW)) u_port (
    .drive_i     (drive),
    .fire_i      (fire),
    .dir_i       (cur_dir),
    .addr_i      (cur_addr),
    .mem_rdata_i (mem_rdata_i),
    .dev_data_i  (dev_data_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .dev_data_o  (dev_data_o),
    .dev_wr_o    (dev_wr_o),
    .dev_ack_o   (dev_ack_o)
  );

  assign bus_en_o = drive;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk
  import dma_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_grant_i,
  input logic          bus_en_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_we_o,
  input logic          dev_wr_o,
  input logic          fire,
  input logic          last,
  input dma_mode_e     cur_mode,
  input logic [AW-1:0] cur_addr
);
  AST_DRIVE_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> (bus_grant_i && bus_req_o)); // R3
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o); // R2
  AST_BURST_KEEPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last && cur_mode == MODE_BURST) |=> bus_req_o); // R4
  AST_STEAL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cur_mode == MODE_STEAL) |=> !bus_req_o); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (cur_addr == AW'($past(cur_addr) + AW'(1)))); // R6
  AST_WE_ON_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || dev_wr_o) |-> bus_en_o); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!bus_req_o && !busy_o)); // R9
endmodule

bind dma_ctrl dma_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_grant_i (bus_grant_i),
  .bus_en_o    (bus_en_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .dev_wr_o    (dev_wr_o),
  .fire        (fire),
  .last        (last),
  .cur_mode    (cur_mode),
  .cur_addr    (cur_addr)
);

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;
  localparam int AW = 16, DW = 16, CW = 16;
  localparam logic [DW-1:0] SENT = 16'hDEAD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0, mode = 1'b0, ready = 1'b1;
  logic [AW-1:0] caddr = '0;
  logic [CW-1:0] ccount = '0;
  logic busy, done, req, grant, en, we, ack, dwr;
  logic [AW-1:0] maddr;
  logic [DW-1:0] wdata, rdata, dout, din;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] rx [16];
  int dev_idx = 0, rx_idx = 0, tenures = 0, words = 0;
  int errors = 0, checks = 0;
  logic grant_d = 1'b0;

  always #2.5 clk = ~clk;

  dma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_addr_i(caddr),
    .cfg_count_i(ccount), .cfg_dir_i(dir), .cfg_mode_i(mode),
    .busy_o(busy), .done_o(done), .bus_req_o(req), .bus_grant_i(grant),
    .bus_en_o(en), .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_rdata_i(rdata), .dev_ready_i(ready), .dev_data_i(din),
    .dev_ack_o(ack), .dev_data_o(dout), .dev_wr_o(dwr)
  );

  assign rdata = mem[maddr[5:0]];
  assign din   = DW'(16'hA000 + dev_idx);

  // processor model: grant follows request by one cycle
  always @(posedge clk or negedge rst_n)
    if (!rst_n) grant <= 1'b0; else grant <= req;

  always @(posedge clk) begin
    grant_d <= grant;
    if (grant && !grant_d) tenures <= tenures + 1;
    if (we || dwr) words <= words + 1;
    if (we) mem[maddr[5:0]] <= wdata;
    if (ack) dev_idx <= dev_idx + 1;
    if (dwr) begin rx[rx_idx[3:0]] <= dout; rx_idx <= rx_idx + 1; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    for (int i = 0; i < 64; i++) mem[i] = SENT;
    dev_idx = 0; rx_idx = 0; tenures = 0; words = 0; ready = 1'b1;
  endtask

  task automatic kick(input int a, input int n, input bit d, input bit m);
    caddr = AW'(a); ccount = CW'(n); dir = d; mode = m; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  // counts edges from the start edge until done reads 1 at a falling edge
  task automatic wait_done(output int cyc);
    cyc = 1;
    @(negedge clk);
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    chk(req == 0, "R1 req", int'(req), 0);
    chk(en == 0, "R1 en", int'(en), 0);
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(done == 0, "R1 done", int'(done), 0);
  endtask

  task automatic t_burst_d2m();
    int cyc, bad = 0;
    prep();
    kick(8, 6, 1'b0, 1'b0);
    wait_done(cyc);
    chk(cyc == 10, "R4 burst latency", cyc, 10);
    chk(tenures == 1, "R4 burst tenures", tenures, 1);
    for (int i = 0; i < 6; i++) if (mem[8+i] != DW'(16'hA000 + i)) bad++;
    chk(bad == 0, "R7 dev2mem data", bad, 0);
    chk(mem[7] == SENT && mem[14] == SENT, "R6 range bounds", int'(mem[14]), int'(SENT));
    chk(req == 0 && busy == 0, "R9 release at done", int'(req), 0);
    repeat (4) @(negedge clk);
    chk(done == 1, "R9 done sticky", int'(done), 1);
  endtask

  task automatic t_steal_m2d();
    int cyc, bad = 0;
    prep();
    for (int i = 0; i < 4; i++) mem[20+i] = DW'(16'h5100 + i * 3);
    kick(20, 4, 1'b1, 1'b1);
    @(negedge clk);
    chk(done == 0, "R9 start clears done", int'(done), 0);
    wait_done(cyc);
    cyc++;
    chk(cyc == 17, "R5 steal latency", cyc, 17);
    chk(tenures == 4, "R5 steal tenures", tenures, 4);
    for (int i = 0; i < 4; i++) if (rx[i] != DW'(16'h5100 + i * 3)) bad++;
    chk(bad == 0 && rx_idx == 4, "R8 mem2dev data", bad, 0);
    chk(mem[20] == DW'(16'h5100), "R8 memory untouched", int'(mem[20]), 'h5100);
  endtask

  task automatic t_wait_ready();
    int cyc, bad = 0;
    prep();
    ready = 1'b0;
    kick(33, 3, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk(req == 0, "R2 no request before ready", int'(req), 0);
    chk(busy == 1, "R2 busy while waiting", int'(busy), 1);
    ready = 1'b1;
    wait_done(cyc);
    chk(tenures == 3, "R5 steal tenures after wait", tenures, 3);
    for (int i = 0; i < 3; i++) if (mem[33+i] != DW'(16'hA000 + i)) bad++;
    chk(bad == 0, "R6 steal addresses", bad, 0);
  endtask

  task automatic t_burst_stall();
    int cyc, w, bad = 0;
    prep();
    kick(40, 8, 1'b0, 1'b0);
    while (!en) @(negedge clk);
    repeat (2) @(negedge clk);
    ready = 1'b0;
    w = words;
    repeat (3) @(negedge clk);
    chk(words == w, "R12 no word while stalled", words, w);
    chk(req == 1, "R12 bus held while stalled", int'(req), 1);
    ready = 1'b1;
    wait_done(cyc);
    chk(tenures == 1, "R12 single tenure", tenures, 1);
    for (int i = 0; i < 8; i++) if (mem[40+i] != DW'(16'hA000 + i)) bad++;
    chk(bad == 0, "R12 data after stall", bad, 0);
  endtask

  task automatic t_zero();
    prep();
    kick(5, 0, 1'b0, 1'b0);
    @(negedge clk);
    chk(done == 1, "R10 zero count done", int'(done), 1);
    chk(busy == 0, "R10 zero count idle", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(tenures == 0 && words == 0, "R10 no bus activity", tenures, 0);
  endtask

  task automatic t_start_busy();
    int cyc, bad = 0;
    prep();
    kick(50, 5, 1'b0, 1'b0);
    @(negedge clk);
    kick(58, 3, 1'b1, 1'b1);
    wait_done(cyc);
    for (int i = 0; i < 5; i++) if (mem[50+i] != DW'(16'hA000 + i)) bad++;
    chk(bad == 0 && words == 5, "R11 original block kept", words, 5);
    chk(mem[58] == SENT && tenures == 1, "R11 second start ignored", tenures, 1);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_burst_d2m();
    t_steal_m2d();
    t_wait_ready();
    t_burst_stall();
    t_zero();
    t_start_busy();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule